// File: doc/BRIEF.md
# Master Clock Rate Detector

This block works out which of three master clock rates is feeding it: 2.048 MHz, 4.096 MHz or 8.192 MHz. It needs no configuration pin. It counts master clock cycles between successive rising edges of the 8 kHz transmit frame sync, which is an integer divisor of the master clock. A period near 256 cycles means the slowest rate, near 512 the middle rate, and near 1024 the fastest.

The frame sync arrives asynchronously. It passes through a two-flop synchronizer, and only its rising edge is used. A rate is adopted, and the lock flag raised, only after two consecutive in-window measurements agree. A measurement outside every window clears lock, and so does a gap of more than 2048 cycles without a frame sync edge. In both cases the last adopted rate is kept.

From the adopted rate the block produces a periodic clock enable. It fires every 1, 2 or 4 master clocks, so the downstream processing sees a 2.048 MHz effective rate whichever clock is fitted.

Top module: `mclk_rate_detect`

## Requirements
- R1: While reset is applied, and after it, `rate_locked` is 0 and `rate_code` is 0 (the 2.048 MHz code) until a lock is reached.
- R2: A measured frame period of 254..258 cycles classifies as code 0 (2.048 MHz). 510..514 cycles classifies as code 1 (4.096 MHz). 1022..1026 cycles classifies as code 2 (8.192 MHz). All bounds are inclusive, and at most one window matches.
- R3: `rate_code` changes, and `rate_locked` rises, only after two consecutive in-window measurements give the same code. A single measurement that disagrees leaves both outputs unchanged.
- R4: An out-of-window measurement (for example 253, 300, 700 or 1027 cycles) clears `rate_locked` and leaves `rate_code` unchanged.
- R5: If 2048 cycles pass with no frame sync rising edge, `rate_locked` clears and `rate_code` is held. The next edge only restarts measurement, so two further full periods are needed to lock again.
- R6: `tick_en` is high on every cycle for code 0, on one cycle in 2 for code 1, and on one cycle in 4 for code 2.
- R7: `rate_code` never takes the value 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| mclk | input | 1 | Master clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| fsync_async | input | 1 | 8 kHz transmit frame sync, asynchronous to `mclk` |
| rate_code | output | 2 | Adopted rate: 0 = 2.048 MHz, 1 = 4.096 MHz, 2 = 8.192 MHz |
| rate_locked | output | 1 | High while two agreeing measurements stand and no fault has followed |
| tick_en | output | 1 | Clock enable giving a 2.048 MHz effective rate |

## Verification
The hardest situation to reach is a lock that is held across a single disagreeing frame, followed by a later switch to a new rate. This requires the candidate code to be replaced without the adopted code moving. The bench places every frame sync edge at an exact cycle offset from the previous one, so each measured period is exactly the number in the stimulus. A run of alternating periods (512, 256, 512, 512) then shows that the rate changes only on the second of two agreeing frames. The timeout case is reached by withholding the frame sync for more than 2048 cycles and then checking that the first edge afterwards does not count as a measurement.

// File: rtl/mrd_pkg.sv
package mrd_pkg;
  localparam int unsigned NUM_RATES = 3;
  localparam int unsigned CODE_W    = 2;
  localparam int unsigned DIV_W     = NUM_RATES - 1;

  typedef enum logic [CODE_W-1:0] {
    RATE_X1 = 2'd0,
    RATE_X2 = 2'd1,
    RATE_X4 = 2'd2
  } rate_e;
endpackage

// File: rtl/mrd_sync_edge.sv
module mrd_sync_edge #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din_async,
  output logic rise
);
  logic [STAGES:0] sh_q;
  logic [STAGES:0] sh_d;

  always_comb begin
    sh_d = {sh_q[STAGES-1:0], din_async};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '0;
    else        sh_q <= sh_d;
  end

  assign rise = sh_q[STAGES-1] & ~sh_q[STAGES];
endmodule

// File: rtl/mrd_period_meter.sv
module mrd_period_meter #(
  parameter int unsigned TIMEOUT_CYC = 2048,
  localparam int unsigned CW = $clog2(TIMEOUT_CYC + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          edge_in,
  output logic          meas_vld,
  output logic [CW-1:0] meas_cnt,
  output logic          tmo
);
  localparam logic [CW-1:0] LIMIT = CW'(TIMEOUT_CYC);

  logic [CW-1:0] cnt_q, cnt_d;
  logic [CW-1:0] meas_q, meas_d;
  logic          armed_q, armed_d;
  logic          vld_q, vld_d;
  logic          tmo_q, tmo_d;

  always_comb begin
    cnt_d   = cnt_q;
    meas_d  = meas_q;
    armed_d = armed_q;
    vld_d   = 1'b0;
    tmo_d   = 1'b0;
    if (edge_in) begin
      vld_d   = armed_q;
      meas_d  = cnt_q;
      cnt_d   = CW'(1);
      armed_d = 1'b1;
    end else if (cnt_q == LIMIT) begin
      tmo_d   = 1'b1;
      armed_d = 1'b0;
      cnt_d   = '0;
    end else begin
      cnt_d   = cnt_q + CW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      meas_q  <= '0;
      armed_q <= 1'b0;
      vld_q   <= 1'b0;
      tmo_q   <= 1'b0;
    end else begin
      cnt_q   <= cnt_d;
      meas_q  <= meas_d;
      armed_q <= armed_d;
      vld_q   <= vld_d;
      tmo_q   <= tmo_d;
    end
  end

  assign meas_vld = vld_q;
  assign meas_cnt = meas_q;
  assign tmo      = tmo_q;
endmodule

// File: rtl/mrd_classifier.sv
module mrd_classifier
  import mrd_pkg::*;
#(
  parameter int unsigned CW        = 12,
  parameter int unsigned BASE_CNT  = 256,
  parameter int unsigned TOLERANCE = 2
) (
  input  logic [CW-1:0]        meas_cnt,
  output logic [NUM_RATES-1:0] hit_vec,
  output logic                 in_win,
  output logic [CODE_W-1:0]    hit_code
);
  for (genvar gi = 0; gi < NUM_RATES; gi++) begin : g_win
    localparam int unsigned NOM = BASE_CNT << gi;
    localparam logic [CW:0] LO  = (CW+1)'(NOM - TOLERANCE);
    localparam logic [CW:0] HI  = (CW+1)'(NOM + TOLERANCE);
    assign hit_vec[gi] = ({1'b0, meas_cnt} >= LO) && ({1'b0, meas_cnt} <= HI);
  end

  always_comb begin
    hit_code = '0;
    for (int i = NUM_RATES - 1; i >= 0; i--) begin
      if (hit_vec[i]) hit_code = CODE_W'(i);
    end
  end

  assign in_win = |hit_vec;
endmodule

// File: rtl/mrd_lock_ctrl.sv
module mrd_lock_ctrl
  import mrd_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              meas_vld,
  input  logic              in_win,
  input  logic [CODE_W-1:0] hit_code,
  input  logic              tmo,
  output logic [CODE_W-1:0] rate_code,
  output logic              locked
);
  logic [CODE_W-1:0] rate_q, rate_d;
  logic [CODE_W-1:0] cand_q, cand_d;
  logic              cand_ok_q, cand_ok_d;
  logic              lock_q, lock_d;

  always_comb begin
    rate_d    = rate_q;
    cand_d    = cand_q;
    cand_ok_d = cand_ok_q;
    lock_d    = lock_q;
    if (tmo || (meas_vld && !in_win)) begin
      lock_d    = 1'b0;
      cand_ok_d = 1'b0;
    end else if (meas_vld) begin
      if (cand_ok_q && (cand_q == hit_code)) begin
        rate_d = hit_code;
        lock_d = 1'b1;
      end else begin
        cand_d    = hit_code;
        cand_ok_d = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rate_q    <= RATE_X1;
      cand_q    <= RATE_X1;
      cand_ok_q <= 1'b0;
      lock_q    <= 1'b0;
    end else begin
      rate_q    <= rate_d;
      cand_q    <= cand_d;
      cand_ok_q <= cand_ok_d;
      lock_q    <= lock_d;
    end
  end

  assign rate_code = rate_q;
  assign locked    = lock_q;
endmodule

// File: rtl/mrd_tick_gen.sv
module mrd_tick_gen
  import mrd_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CODE_W-1:0] rate_code,
  output logic              tick
);
  logic [DIV_W-1:0] div_q, div_d;
  logic [DIV_W:0]   lim;

  always_comb begin
    lim = ((DIV_W+1)'(1) << rate_code) - (DIV_W+1)'(1);
    if ({1'b0, div_q} >= lim) div_d = '0;
    else                      div_d = div_q + DIV_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) div_q <= '0;
    else        div_q <= div_d;
  end

  assign tick = (div_q == '0);
endmodule

// File: rtl/mclk_rate_detect.sv
module mclk_rate_detect
  import mrd_pkg::*;
#(
  parameter int unsigned BASE_CNT    = 256,
  parameter int unsigned TOLERANCE   = 2,
  parameter int unsigned TIMEOUT_CYC = 2048,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic       mclk,
  input  logic       rst_n,
  input  logic       fsync_async,
  output logic [1:0] rate_code,
  output logic       rate_locked,
  output logic       tick_en
);
  localparam int unsigned CW = $clog2(TIMEOUT_CYC + 1);

  logic [1:0]           rst_sh_q;
  logic                 rst_n_s;
  logic                 fs_edge;
  logic                 meas_vld;
  logic [CW-1:0]        meas_cnt;
  logic                 tmo;
  logic [NUM_RATES-1:0] hit_vec;
  logic                 in_win;
  logic [CODE_W-1:0]    hit_code;
  logic [CODE_W-1:0]    rate_q;

  always_ff @(posedge mclk or negedge rst_n) begin
    if (!rst_n) rst_sh_q <= '0;
    else        rst_sh_q <= {rst_sh_q[0], 1'b1};
  end
  assign rst_n_s = rst_sh_q[1];

  mrd_sync_edge #(.STAGES(SYNC_STAGES)) u_sync (
    .clk       (mclk),
    .rst_n     (rst_n_s),
    .din_async (fsync_async),
    .rise      (fs_edge)
  );

  mrd_period_meter #(.TIMEOUT_CYC(TIMEOUT_CYC)) u_meter (
    .clk      (mclk),
    .rst_n    (rst_n_s),
    .edge_in  (fs_edge),
    .meas_vld (meas_vld),
    .meas_cnt (meas_cnt),
    .tmo      (tmo)
  );

  mrd_classifier #(
    .CW        (CW),
    .BASE_CNT  (BASE_CNT),
    .TOLERANCE (TOLERANCE)
  ) u_class (
    .meas_cnt (meas_cnt),
    .hit_vec  (hit_vec),
    .in_win   (in_win),
    .hit_code (hit_code)
  );

  mrd_lock_ctrl u_lock (
    .clk       (mclk),
    .rst_n     (rst_n_s),
    .meas_vld  (meas_vld),
    .in_win    (in_win),
    .hit_code  (hit_code),
    .tmo       (tmo),
    .rate_code (rate_q),
    .locked    (rate_locked)
  );

  mrd_tick_gen u_tick (
    .clk       (mclk),
    .rst_n     (rst_n_s),
    .rate_code (rate_q),
    .tick      (tick_en)
  );

  assign rate_code = rate_q;
endmodule

// File: rtl/mrd_checker.sv
module mrd_checker #(
  parameter int unsigned NR = 3
) (
  input logic          clk,
  input logic          rst_n,
  input logic          meas_vld,
  input logic          in_win,
  input logic          tmo,
  input logic [NR-1:0] hit_vec,
  input logic [1:0]    rate_code,
  input logic          locked,
  input logic          tick
);
  AST_WINDOW_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(hit_vec)); // R2

  AST_RATE_MOVE_NEEDS_MEAS: assert property (@(posedge clk) disable iff (!rst_n)
    $changed(rate_code) |-> ($past(meas_vld) && $past(in_win))); // R3

  AST_RATE_MOVE_LOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    $changed(rate_code) |-> locked); // R3

  AST_LOCK_RISE_NEEDS_MEAS: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(locked) |-> $past(meas_vld)); // R3

  AST_MISS_DROPS_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
    (meas_vld && !in_win) |=> (!locked && $stable(rate_code))); // R4

  AST_TIMEOUT_DROPS_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
    tmo |=> (!locked && $stable(rate_code))); // R5

  AST_TICK_FULL_RATE: assert property (@(posedge clk) disable iff (!rst_n)
    ((rate_code == 2'd0) && ($past(rate_code) == 2'd0)) |-> tick); // R6

  AST_TICK_SPACING: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && (rate_code != 2'd0)) |=> !tick); // R6

  AST_CODE_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    rate_code != 2'b11); // R7
endmodule

bind mclk_rate_detect mrd_checker #(.NR(mrd_pkg::NUM_RATES)) u_chk (
  .clk       (mclk),
  .rst_n     (rst_n_s),
  .meas_vld  (meas_vld),
  .in_win    (in_win),
  .tmo       (tmo),
  .hit_vec   (hit_vec),
  .rate_code (rate_q),
  .locked    (rate_locked),
  .tick      (tick_en)
);

// File: tb/mclk_rate_detect_bench.sv
module mclk_rate_detect_bench;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       fs;
  logic [1:0] code;
  logic       lock;
  logic       tick;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;
  int last_rise = 0;

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  mclk_rate_detect u_mclk_rate_detect (
    .mclk        (clk),
    .rst_n       (rst_n),
    .fsync_async (fs),
    .rate_code   (code),
    .rate_locked (lock),
    .tick_en     (tick)
  );

  // {period[11:0], pulses[3:0], exp_lock, exp_code[1:0]}
  localparam logic [18:0] VEC [12] = '{
    {12'd256,  4'd3, 1'b1, 2'd0},
    {12'd512,  4'd3, 1'b1, 2'd1},
    {12'd1024, 4'd3, 1'b1, 2'd2},
    {12'd254,  4'd3, 1'b1, 2'd0},
    {12'd1026, 4'd3, 1'b1, 2'd2},
    {12'd510,  4'd3, 1'b1, 2'd1},
    {12'd514,  4'd3, 1'b1, 2'd1},
    {12'd300,  4'd2, 1'b0, 2'd1},
    {12'd1022, 4'd3, 1'b1, 2'd2},
    {12'd1027, 4'd2, 1'b0, 2'd2},
    {12'd253,  4'd2, 1'b0, 2'd2},
    {12'd258,  4'd3, 1'b1, 2'd0}
  };

  task automatic check_eq(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic send_frames(input int period, input int n);
    for (int k = 0; k < n; k++) begin
      while (cyc < last_rise + period) @(negedge clk);
      fs = 1'b1;
      last_rise = cyc;
      repeat (4) @(negedge clk);
      fs = 1'b0;
    end
  endtask

  task automatic count_ticks(input string req, input int exp);
    int n;
    n = 0;
    for (int k = 0; k < 16; k++) begin
      @(negedge clk);
      if (tick) n++;
    end
    check_eq(req, "ticks in 16 cycles", n, exp);
  endtask

  task automatic settle_and_check(input string req, input int exp_lock, input int exp_code);
    repeat (8) @(negedge clk);
    check_eq(req, "lock", int'(lock), exp_lock);
    check_eq(req, "code", int'(code), exp_code);
    check_eq("R7", "code legal", int'(code == 2'b11), 0);
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    fs = 1'b0;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    // R1: reset values while held
    check_eq("R1", "lock in reset", int'(lock), 0);
    check_eq("R1", "code in reset", int'(code), 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    last_rise = cyc;
    check_eq("R1", "lock after reset", int'(lock), 0);
    check_eq("R1", "code after reset", int'(code), 0);
    count_ticks("R6", 16);

    // table walk: R2 windows, R3 lock, R4 misses, R6 tick spacing
    for (int v = 0; v < 12; v++) begin
      send_frames(int'(VEC[v][18:7]), int'(VEC[v][6:3]));
      settle_and_check(VEC[v][2] ? "R2" : "R4", int'(VEC[v][2]), int'(VEC[v][1:0]));
      count_ticks("R6", 16 >> VEC[v][1:0]);
    end

    // R3: a lone disagreeing frame changes nothing
    send_frames(512, 1);
    settle_and_check("R3", 1, 0);
    send_frames(256, 1);
    settle_and_check("R3", 1, 0);
    send_frames(512, 1);
    settle_and_check("R3", 1, 0);
    send_frames(512, 1);
    settle_and_check("R3", 1, 1);

    // R5: frame sync withheld past the timeout
    repeat (2100) @(negedge clk);
    check_eq("R5", "lock after timeout", int'(lock), 0);
    check_eq("R5", "code held after timeout", int'(code), 1);
    count_ticks("R6", 8);
    last_rise = cyc;
    send_frames(1024, 2);
    settle_and_check("R5", 0, 1);
    send_frames(1024, 1);
    settle_and_check("R5", 1, 2);
    count_ticks("R6", 4);

    // R1: reset in mid-run returns to defaults
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    check_eq("R1", "lock on mid-run reset", int'(lock), 0);
    check_eq("R1", "code on mid-run reset", int'(code), 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    count_ticks("R6", 16);

    finish_run();
  end
endmodule